// File: doc/BRIEF.md
# Two-Level Micro-Op Loop Sequencer

This block runs one compute instruction. It takes a contiguous range of micro-ops in a micro-op memory and replays that range inside two nested counted loops. The loops are an outer count and an inner count. Each micro-op holds three base indices: destination, source and weight. For every micro-op it issues, the block adds an offset to each base index. The offset is a linear function of the two loop counters, so a short stored list of micro-ops expands into a long strided sequence of index triples for the arithmetic stage downstream.

The instruction fields are sampled when a start pulse is accepted while the block is idle. The block drives the micro-op memory read address. That memory returns data one cycle later. The block pairs each returned word with the loop-counter state under which it was fetched, so every emitted triple carries its own offsets. Triples leave on a valid/ready stream, one per cycle while ready stays high. A one-cycle done pulse closes each instruction. A per-instruction clear flag travels with every triple. The flag tells downstream to overwrite the destination entry instead of accumulating into it.

Top module: `uopLoopSeq`

## Requirements
- R1: Triples are issued in nested order. The outer counter changes slowest, then the inner counter, then the micro-op address, which runs from the begin address up to, but not including, the end address.
- R2: The emitted destination index equals the micro-op destination field plus inner counter times the inner destination factor plus outer counter times the outer destination factor.
- R3: The source and weight indices follow the same rule as R2, each with its own inner and outer factors.
- R4: A micro-op word holds the destination index in bits [ACC_W-1:0], the source index in the next SRC_W bits, and the weight index in the WGT_W bits above those.
- R5: Every index sum wraps modulo two to the power of its own field width.
- R6: The clear flag sampled at start appears on the clear output alongside every triple of that instruction.
- R7: If either loop count is zero, or the begin address is not below the end address, no triple is issued and done pulses in the cycle after the start is accepted.
- R8: While a triple is valid and ready is low, the valid signal and all three indices hold their values. While ready is high, one triple is transferred per cycle.
- R9: Done is a single-cycle pulse that comes in the cycle after the final transfer, once per instruction.
- R10: The end address may equal the micro-op memory depth, in which case the last entry of the memory is included.
- R11: A start pulse while the block is busy is ignored and does not change the running sequence.
- R12: After reset the block is idle, with valid and done both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| idle | output | 1 | High when no instruction is in progress |
| uopBgn | input | UA_W | First micro-op address |
| uopEnd | input | UA_W+1 | End micro-op address, exclusive |
| iterOut | input | ITER_W | Outer loop count |
| iterIn | input | ITER_W | Inner loop count |
| dstFacOut | input | ACC_W | Outer destination factor |
| dstFacIn | input | ACC_W | Inner destination factor |
| srcFacOut | input | SRC_W | Outer source factor |
| srcFacIn | input | SRC_W | Inner source factor |
| wgtFacOut | input | WGT_W | Outer weight factor |
| wgtFacIn | input | WGT_W | Inner weight factor |
| clearIn | input | 1 | Clear-destination flag of the instruction |
| uopAddr | output | UA_W | Micro-op memory read address |
| uopRdData | input | ACC_W+SRC_W+WGT_W | Micro-op word, one cycle after the address |
| outValid | output | 1 | Index triple valid |
| outReady | input | 1 | Downstream accepts the triple |
| outDst | output | ACC_W | Adjusted destination index |
| outSrc | output | SRC_W | Adjusted source index |
| outWgt | output | WGT_W | Adjusted weight index |
| outClear | output | 1 | Clear flag for this triple |
| done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
The bench builds the block with an 8-entry micro-op memory and index widths of 5, 4 and 3 bits. With so few entries, an end address equal to the memory depth is easy to test. With such narrow fields, modest factors and loop counts already push every index sum past its modulus, so wrapping is exercised on all three indices. The 14-bit loop counts keep their full width, but the bench uses small counts so that every triple can be compared against a behavioural nested-loop model, with ready both held high and toggled at random.

// File: rtl/uopLoopSeq_pkg.sv
package uopLoopSeq_pkg;
  typedef struct packed {
    logic load;     // capture a new instruction
    logic adv;      // the output stage takes the next fetched micro-op
    logic fetchOn;  // the fetch pointer holds a live micro-op
    logic stepIn;   // the inner counter advances with this fetch
    logic stepOut;  // the outer counter advances with this fetch
  } seqStb_t;
endpackage

// File: rtl/uopLoopSeq_ctrl.sv
module uopLoopSeq_ctrl
  import uopLoopSeq_pkg::*;
#(
  parameter int UA_W   = 10,
  parameter int ITER_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [UA_W-1:0]   uopBgn,
  input  logic [UA_W:0]     uopEnd,
  input  logic [ITER_W-1:0] iterOut,
  input  logic [ITER_W-1:0] iterIn,
  input  logic              clearIn,
  input  logic              outReady,
  output seqStb_t           stb,
  output logic              idle,
  output logic              stValid,
  output logic              clearOut,
  output logic              done,
  output logic [UA_W-1:0]   uopAddr
);
  logic              fetchOn, sValid, sLast, doneR, clrR;
  logic [UA_W-1:0]   fK, sK, bgnR;
  logic [UA_W:0]     endR;
  logic [ITER_W-1:0] fJ, fI, itInR, itOutR;
  logic accept, emptyReq, adv, kLast, jLast, iLast;

  assign idle     = !fetchOn && !sValid;
  assign accept   = start && idle;
  assign emptyReq = (iterOut == '0) || (iterIn == '0) || ({1'b0, uopBgn} >= uopEnd);
  assign adv      = !sValid || outReady;
  assign kLast    = ({1'b0, fK} + {{UA_W{1'b0}}, 1'b1}) == endR;
  assign jLast    = fJ == (itInR - 1'b1);
  assign iLast    = fI == (itOutR - 1'b1);

  assign stb.load    = accept && !emptyReq;
  assign stb.adv     = adv;
  assign stb.fetchOn = fetchOn;
  assign stb.stepIn  = kLast;
  assign stb.stepOut = kLast && jLast;

  assign uopAddr  = adv ? fK : sK;
  assign stValid  = sValid;
  assign clearOut = clrR;
  assign done     = doneR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchOn <= 1'b0;
      sValid  <= 1'b0;
      sLast   <= 1'b0;
      doneR   <= 1'b0;
      clrR    <= 1'b0;
      fK      <= '0;
      sK      <= '0;
      bgnR    <= '0;
      endR    <= '0;
      fJ      <= '0;
      fI      <= '0;
      itInR   <= '0;
      itOutR  <= '0;
    end else begin
      doneR <= (accept && emptyReq) || (sValid && sLast && outReady);
      if (stb.load) begin
        fetchOn <= 1'b1;
        sValid  <= 1'b0;
        fK      <= uopBgn;
        fJ      <= '0;
        fI      <= '0;
        bgnR    <= uopBgn;
        endR    <= uopEnd;
        itInR   <= iterIn;
        itOutR  <= iterOut;
        clrR    <= clearIn;
      end else if (adv) begin
        sValid <= fetchOn;
        if (fetchOn) begin
          sK    <= fK;
          sLast <= kLast && jLast && iLast;
          if (kLast) begin
            fK <= bgnR;
            if (jLast) begin
              fJ <= '0;
              if (iLast) fetchOn <= 1'b0;
              else       fI <= fI + 1'b1;
            end else begin
              fJ <= fJ + 1'b1;
            end
          end else begin
            fK <= fK + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uopLoopSeq_idx.sv
module uopLoopSeq_idx
  import uopLoopSeq_pkg::*;
#(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rstN,
  input  seqStb_t      stb,
  input  logic [W-1:0] facIn,
  input  logic [W-1:0] facOut,
  input  logic [W-1:0] base,
  output logic [W-1:0] idx
);
  // Running offsets replace multipliers: offIn tracks inner*facIn, offOut outer*facOut.
  logic [W-1:0] facInR, facOutR, offIn, offOut, stOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      facInR  <= '0;
      facOutR <= '0;
      offIn   <= '0;
      offOut  <= '0;
      stOff   <= '0;
    end else if (stb.load) begin
      facInR  <= facIn;
      facOutR <= facOut;
      offIn   <= '0;
      offOut  <= '0;
    end else if (stb.adv && stb.fetchOn) begin
      stOff <= offIn + offOut;
      if (stb.stepOut) begin
        offIn  <= '0;
        offOut <= offOut + facOutR;
      end else if (stb.stepIn) begin
        offIn <= offIn + facInR;
      end
    end
  end

  assign idx = base + stOff;
endmodule

// File: rtl/uopLoopSeq.sv
module uopLoopSeq
  import uopLoopSeq_pkg::*;
#(
  parameter int UA_W   = 10,
  parameter int ITER_W = 14,
  parameter int ACC_W  = 11,
  parameter int SRC_W  = 11,
  parameter int WGT_W  = 10,
  localparam int UOP_W = ACC_W + SRC_W + WGT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              idle,
  input  logic [UA_W-1:0]   uopBgn,
  input  logic [UA_W:0]     uopEnd,
  input  logic [ITER_W-1:0] iterOut,
  input  logic [ITER_W-1:0] iterIn,
  input  logic [ACC_W-1:0]  dstFacOut,
  input  logic [ACC_W-1:0]  dstFacIn,
  input  logic [SRC_W-1:0]  srcFacOut,
  input  logic [SRC_W-1:0]  srcFacIn,
  input  logic [WGT_W-1:0]  wgtFacOut,
  input  logic [WGT_W-1:0]  wgtFacIn,
  input  logic              clearIn,
  output logic [UA_W-1:0]   uopAddr,
  input  logic [UOP_W-1:0]  uopRdData,
  output logic              outValid,
  input  logic              outReady,
  output logic [ACC_W-1:0]  outDst,
  output logic [SRC_W-1:0]  outSrc,
  output logic [WGT_W-1:0]  outWgt,
  output logic              outClear,
  output logic              done
);
  seqStb_t stb;

  uopLoopSeq_ctrl #(.UA_W(UA_W), .ITER_W(ITER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .uopBgn(uopBgn), .uopEnd(uopEnd),
    .iterOut(iterOut), .iterIn(iterIn), .clearIn(clearIn), .outReady(outReady),
    .stb(stb), .idle(idle), .stValid(outValid), .clearOut(outClear),
    .done(done), .uopAddr(uopAddr)
  );

  uopLoopSeq_idx #(.W(ACC_W)) u_dst (
    .clk(clk), .rstN(rstN), .stb(stb), .facIn(dstFacIn), .facOut(dstFacOut),
    .base(uopRdData[ACC_W-1:0]), .idx(outDst)
  );

  uopLoopSeq_idx #(.W(SRC_W)) u_src (
    .clk(clk), .rstN(rstN), .stb(stb), .facIn(srcFacIn), .facOut(srcFacOut),
    .base(uopRdData[ACC_W+SRC_W-1:ACC_W]), .idx(outSrc)
  );

  uopLoopSeq_idx #(.W(WGT_W)) u_wgt (
    .clk(clk), .rstN(rstN), .stb(stb), .facIn(wgtFacIn), .facOut(wgtFacOut),
    .base(uopRdData[UOP_W-1:ACC_W+SRC_W]), .idx(outWgt)
  );
endmodule

// File: rtl/uopLoopSeq_chk.sv
module uopLoopSeq_chk #(
  parameter int ACC_W = 11,
  parameter int SRC_W = 11,
  parameter int WGT_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             idle,
  input logic             outValid,
  input logic             outReady,
  input logic [ACC_W-1:0] outDst,
  input logic [SRC_W-1:0] outSrc,
  input logic [WGT_W-1:0] outWgt,
  input logic             outClear,
  input logic             done
);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outDst) && $stable(outSrc) && $stable(outWgt)));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !outValid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid);

  assert_clear_steady_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> $stable(outClear));
endmodule

bind uopLoopSeq uopLoopSeq_chk #(.ACC_W(ACC_W), .SRC_W(SRC_W), .WGT_W(WGT_W)) u_chk (
  .clk(clk), .rstN(rstN), .idle(idle), .outValid(outValid), .outReady(outReady),
  .outDst(outDst), .outSrc(outSrc), .outWgt(outWgt), .outClear(outClear), .done(done)
);

// File: tb/uopLoopSeq_tb.sv
module uopLoopSeq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int UA_W = 3;
  localparam int ITER_W = 14;
  localparam int ACC_W = 5;
  localparam int SRC_W = 4;
  localparam int WGT_W = 3;
  localparam int UOP_W = ACC_W + SRC_W + WGT_W;
  localparam int DEPTH = 1 << UA_W;
  localparam int ENT_W = UOP_W + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic idle;
  logic [UA_W-1:0] uopBgn = '0;
  logic [UA_W:0] uopEnd = '0;
  logic [ITER_W-1:0] iterOut = '0, iterIn = '0;
  logic [ACC_W-1:0] dstFacOut = '0, dstFacIn = '0;
  logic [SRC_W-1:0] srcFacOut = '0, srcFacIn = '0;
  logic [WGT_W-1:0] wgtFacOut = '0, wgtFacIn = '0;
  logic clearIn = 1'b0;
  logic [UA_W-1:0] uopAddr;
  logic [UOP_W-1:0] uopRdData = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [ACC_W-1:0] outDst;
  logic [SRC_W-1:0] outSrc;
  logic [WGT_W-1:0] outWgt;
  logic outClear;
  logic done;

  logic [UOP_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] expQ[$];
  int errors = 0;
  int checks = 0;
  int readyMode = 0;
  bit expDone = 0;
  bit stallPrev = 0;
  logic [ACC_W-1:0] hDst;
  logic [SRC_W-1:0] hSrc;
  logic [WGT_W-1:0] hWgt;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) uopRdData <= mem[uopAddr];

  uopLoopSeq #(.UA_W(UA_W), .ITER_W(ITER_W), .ACC_W(ACC_W), .SRC_W(SRC_W), .WGT_W(WGT_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .idle(idle), .uopBgn(uopBgn), .uopEnd(uopEnd),
    .iterOut(iterOut), .iterIn(iterIn), .dstFacOut(dstFacOut), .dstFacIn(dstFacIn),
    .srcFacOut(srcFacOut), .srcFacIn(srcFacIn), .wgtFacOut(wgtFacOut), .wgtFacIn(wgtFacIn),
    .clearIn(clearIn), .uopAddr(uopAddr), .uopRdData(uopRdData), .outValid(outValid),
    .outReady(outReady), .outDst(outDst), .outSrc(outSrc), .outWgt(outWgt),
    .outClear(outClear), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: compares the outputs against the expected queue on every falling edge.
  always @(negedge clk) begin
    if (rstN) begin
      outReady = (readyMode == 0) ? 1'b1 : (($urandom % 4) != 0);
      chk(done == expDone, "R9 done timing", done, expDone);
      expDone = 0;
      if (stallPrev) begin
        chk(outValid === 1'b1, "R8 valid held", outValid, 1);
        chk(outDst == hDst && outSrc == hSrc && outWgt == hWgt, "R8 indices held",
            {outDst, outSrc, outWgt}, {hDst, hSrc, hWgt});
      end
      stallPrev = outValid && !outReady;
      hDst = outDst; hSrc = outSrc; hWgt = outWgt;
      if (outValid) begin
        if (expQ.size() == 0) begin
          chk(0, "R1 R11 unexpected triple", outDst, -1);
        end else if (outReady) begin
          logic [ENT_W-1:0] e;
          e = expQ.pop_front();
          chk(outDst == e[ACC_W-1:0], "R2 R5 destination index", outDst, e[ACC_W-1:0]);
          chk(outSrc == e[ACC_W+SRC_W-1:ACC_W] && outWgt == e[UOP_W-1:ACC_W+SRC_W],
              "R3 R4 source/weight index", {outSrc, outWgt}, e[UOP_W-1:ACC_W]);
          chk(outClear == e[UOP_W], "R6 clear flag", outClear, e[UOP_W]);
          if (expQ.size() == 0) expDone = 1;
        end
      end
    end
  end

  task automatic issue(input int b, input int e, input int io, input int ii,
                       input int dfo, input int dfi, input int sfo, input int sfi,
                       input int wfo, input int wfi, input bit clr, input bit expect_run);
    @(negedge clk); #1;
    uopBgn = b[UA_W-1:0]; uopEnd = e[UA_W:0];
    iterOut = io[ITER_W-1:0]; iterIn = ii[ITER_W-1:0];
    dstFacOut = dfo[ACC_W-1:0]; dstFacIn = dfi[ACC_W-1:0];
    srcFacOut = sfo[SRC_W-1:0]; srcFacIn = sfi[SRC_W-1:0];
    wgtFacOut = wfo[WGT_W-1:0]; wgtFacIn = wfi[WGT_W-1:0];
    clearIn = clr;
    start = 1'b1;
    if (expect_run) begin
      bit any = 0;
      for (int i = 0; i < io; i++)
        for (int j = 0; j < ii; j++)
          for (int k = b; k < e; k++) begin
            logic [ACC_W-1:0] d; logic [SRC_W-1:0] s; logic [WGT_W-1:0] w;
            d = mem[k][ACC_W-1:0] + ACC_W'(j*dfi + i*dfo);
            s = mem[k][ACC_W+SRC_W-1:ACC_W] + SRC_W'(j*sfi + i*sfo);
            w = mem[k][UOP_W-1:ACC_W+SRC_W] + WGT_W'(j*wfi + i*wfo);
            expQ.push_back({clr, w, s, d});
            any = 1;
          end
      if (!any) expDone = 1;
    end
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((!idle || expQ.size() != 0) && n < 2000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R1 all triples delivered", expQ.size(), 0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) mem[k] = UOP_W'((k * 419 + 77) ^ (k << 7));
    repeat (3) @(negedge clk);
    chk(idle === 1'b1, "R12 idle after reset", idle, 1);
    chk(outValid === 1'b0, "R12 valid low after reset", outValid, 0);
    chk(done === 1'b0, "R12 done low after reset", done, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R3: basic nested order with ready high
    issue(0, 3, 2, 3, 7, 1, 5, 2, 3, 1, 0, 1); drain();
    // R5 R6 R10: end equals depth, large factors wrap, clear set, random ready
    readyMode = 1;
    issue(5, 8, 3, 2, 29, 13, 15, 9, 7, 5, 1, 1); drain();
    // single micro-op
    issue(2, 3, 1, 1, 3, 3, 3, 3, 3, 3, 0, 1); drain();
    // R7 empty cases
    readyMode = 0;
    issue(1, 4, 2, 0, 1, 1, 1, 1, 1, 1, 0, 1); drain();
    chk(idle === 1'b1, "R7 idle after zero inner count", idle, 1);
    issue(1, 4, 0, 2, 1, 1, 1, 1, 1, 1, 0, 1); drain();
    issue(4, 4, 2, 2, 1, 1, 1, 1, 1, 1, 0, 1); drain();
    issue(6, 2, 2, 2, 1, 1, 1, 1, 1, 1, 1, 1); drain();
    chk(idle === 1'b1, "R7 idle after reversed range", idle, 1);
    // R11: start while busy is ignored
    readyMode = 1;
    issue(0, 8, 2, 2, 11, 6, 4, 3, 2, 5, 1, 1);
    repeat (4) @(negedge clk);
    issue(3, 5, 4, 4, 1, 1, 1, 1, 1, 1, 0, 0);
    drain();
    chk(idle === 1'b1, "R11 no extra run after busy start", idle, 1);
    // R8 long stalls
    readyMode = 1;
    issue(1, 7, 3, 3, 17, 9, 6, 10, 4, 6, 0, 1); drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule